// File: doc/BRIEF.md
# Serial Flash Command Engine

This block runs one short command on a single-lane serial flash bus each time software asks for it. A command word names an opcode and says whether an address, dummy clocks, outgoing data bytes and incoming data bytes follow it. A separate register holds the address. Two 32-bit registers hold up to eight bytes to send, and two more hold up to eight bytes received. Software writes the command word with its start bit set, polls the busy bit until it drops, and then reads the received bytes.

The engine drives the serial clock, an active-low select and the outgoing data line directly, and samples the incoming data line. It works in clock mode 0: the clock idles low, a bit is launched while the clock is low, and the far side's bit is taken on the rising clock edge. Each half of a serial clock period lasts `SCLK_HALF` system clock cycles. A frame of N bits therefore keeps the engine busy for exactly 2·`SCLK_HALF`·N cycles.

Top module: `fcmd_engine`

## Requirements
- R1: After reset, select is high, clock and data out are low, and every register reads zero.
- R2: The registers are selected by code: command 0, address 1, send-low 2, send-high 3, receive-low 4, receive-high 5. Writing the command register with bit 0 set while idle starts a frame. Bit 0 reads 1 in the first cycle after that write and 0 from then on.
- R3: Command bit 1 reads busy. It is 1 from the cycle after the start write and stays 1 for exactly 2·SCLK_HALF·N cycles, where N is the number of bits in the frame.
- R4: The frame is sent in this order: the opcode (bits 31:24) MSB first, then the address if bit 19 is set, then the dummy clocks (count in bits 11:7) with data out held low, then the send bytes if bit 15 is set, then the receive bytes if bit 23 is set. Data out is low during the receive phase.
- R5: Bits 17:16 give the address byte count minus one. That many low bytes of the address register are sent, the most significant of them first.
- R6: Bits 14:12 give the send byte count minus one. Send byte j is bits 8j+7:8j of {send-high, send-low}, and each byte goes out MSB first.
- R7: Bits 22:20 give the receive byte count minus one. Receive byte j lands in bits 8j+7:8j of {receive-high, receive-low}, with the first bit received going to the byte's MSB. Both receive registers are cleared when a frame starts, so bytes that are not received read 0.
- R8: The clock idles low. Each bit spends SCLK_HALF cycles low and then SCLK_HALF cycles high. Data out changes only while the clock is low. Data in is sampled only on rising edges in the receive phase.
- R9: Select goes low with the start write and stays low for the whole frame. It goes high on the falling clock edge that closes the last bit.
- R10: While busy, writes to the command, address and send registers have no effect, and the running frame continues unchanged.
- R11: A write to the command register with bit 0 clear, made while idle, updates the stored fields and starts no frame. The fields read back with bit 18 and bits 6:2 as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register code for the write |
| reg_wdata | input | 32 | Write data |
| rd_sel | input | 3 | Register code for the combinational read |
| reg_rdata | output | 32 | Read data of the register picked by rd_sel |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low device select |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
A slip in the bit counter or in the phase boundaries shows up as a wrong data-out value within one serial clock period. It also changes the length of the frame, which the per-cycle check of select and busy catches on the exact cycle. A fault in the read capture position shows only when the receive registers are read after the frame. For that reason the device model drives noise on data in outside the receive phase, and each received byte is checked in place. A stale stored command or address shows either as a changed bit on data out in the middle of a frame or as a wrong readback once the frame ends.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    // Bit counter width: 8 opcode + 32 address + 31 dummy + 64 + 64 data < 256
    localparam int BIT_W = 8;

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_ADDR = 3'd1,
        SEL_WLO  = 3'd2,
        SEL_WHI  = 3'd3,
        SEL_RLO  = 3'd4,
        SEL_RHI  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic       rd_en;
        logic [2:0] rd_m1;
        logic       addr_en;
        logic [1:0] addr_m1;
        logic       wr_en;
        logic [2:0] wr_m1;
        logic [4:0] dummy;
    } cmd_t;

    // Bit index at which each phase begins, and the frame length
    typedef struct packed {
        logic [BIT_W-1:0] dmy_s;
        logic [BIT_W-1:0] wr_s;
        logic [BIT_W-1:0] rd_s;
        logic [BIT_W-1:0] total;
    } layout_t;

    function automatic cmd_t unpack_cmd(input logic [31:0] w);
        cmd_t c;
        c.opcode  = w[31:24];
        c.rd_en   = w[23];
        c.rd_m1   = w[22:20];
        c.addr_en = w[19];
        c.addr_m1 = w[17:16];
        c.wr_en   = w[15];
        c.wr_m1   = w[14:12];
        c.dummy   = w[11:7];
        return c;
    endfunction

    function automatic logic [31:0] pack_cmd(input cmd_t c);
        return {c.opcode, c.rd_en, c.rd_m1, c.addr_en, 1'b0, c.addr_m1,
                c.wr_en, c.wr_m1, c.dummy, 7'b0};
    endfunction

    function automatic logic [BIT_W-1:0] byte_bits(input logic en, input logic [2:0] m1);
        return en ? ((BIT_W'(m1) + BIT_W'(1)) << 3) : '0;
    endfunction

    function automatic layout_t plan_frame(input cmd_t c);
        layout_t l;
        l.dmy_s = BIT_W'(8) + byte_bits(c.addr_en, {1'b0, c.addr_m1});
        l.wr_s  = l.dmy_s + BIT_W'(c.dummy);
        l.rd_s  = l.wr_s + byte_bits(c.wr_en, c.wr_m1);
        l.total = l.rd_s + byte_bits(c.rd_en, c.rd_m1);
        return l;
    endfunction
endpackage

// File: rtl/fcmd_tick.sv
module fcmd_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/fcmd_txsel.sv
module fcmd_txsel
    import fcmd_pkg::*;
(
    input  logic [7:0]       opcode,
    input  logic [1:0]       addr_m1,
    input  layout_t          lay,
    input  logic [31:0]      addr,
    input  logic [63:0]      wdata,
    input  logic [BIT_W-1:0] idx,
    output logic             bit_o
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [BIT_W-1:0] rel;

    always_comb begin
        rel   = '0;
        bit_o = 1'b0;
        if (idx < BIT_W'(8)) begin
            rel   = idx ^ BIT_W'(7);
            bit_o = |(opcode & (8'h01 << rel));
        end else if (idx < lay.dmy_s) begin
            // most significant sent address byte first
            rel   = BIT_W'({addr_m1, 3'b111}) - (idx - BIT_W'(8));
            bit_o = |(addr & (32'h1 << rel));
        end else if (idx < lay.wr_s) begin
            bit_o = 1'b0;
        end else if (idx < lay.rd_s) begin
            rel   = (idx - lay.wr_s) ^ BIT_W'(7);
            bit_o = |(wdata & (64'h1 << rel));
        end else if (idx < lay.total) begin
            bit_o = 1'b0;
        end
    end
endmodule

// File: rtl/fcmd_rxcap.sv
module fcmd_rxcap #(
    parameter int DW = 64,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          sample,
    input  logic [PW-1:0] pos,
    input  logic          din,
    output logic [DW-1:0] data
);
    timeunit 1ns;
    timeprecision 100ps;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clear)
                data[i] <= 1'b0;
            else if (sample && (pos == PW'(i)))
                data[i] <= din;
        end
    end
endmodule

// File: rtl/fcmd_engine.sv
module fcmd_engine
    import fcmd_pkg::*;
#(
    parameter int SCLK_HALF = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    input  logic [2:0]  rd_sel,
    output logic [31:0] reg_rdata,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DATA_W = 64;

    cmd_t             cmd_q;
    layout_t          lay;
    logic             exec_q, busy_q, sclk_q, cs_n_q;
    logic [31:0]      addr_q, wlo_q, whi_q;
    logic [BIT_W-1:0] bit_q, rd_pos;
    logic             tick, tx_bit, cfg_wr, accept, sample, in_rd, last_bit;
    logic [DATA_W-1:0] rdata;

    assign cfg_wr   = reg_wr && !busy_q;
    assign accept   = cfg_wr && (reg_sel == SEL_CTRL) && reg_wdata[0];
    assign lay      = plan_frame(cmd_q);
    assign last_bit = (bit_q == lay.total - BIT_W'(1));
    assign sample   = busy_q && tick && !sclk_q;
    assign in_rd    = cmd_q.rd_en && (bit_q >= lay.rd_s);
    assign rd_pos   = (bit_q - lay.rd_s) ^ BIT_W'(7);

    fcmd_tick #(.HALF(SCLK_HALF)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (busy_q),
        .tick (tick)
    );

    fcmd_txsel u_tx (
        .opcode  (cmd_q.opcode),
        .addr_m1 (cmd_q.addr_m1),
        .lay     (lay),
        .addr    (addr_q),
        .wdata   ({whi_q, wlo_q}),
        .idx     (bit_q),
        .bit_o   (tx_bit)
    );

    fcmd_rxcap #(.DW(DATA_W), .PW(BIT_W)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .sample (sample && in_rd),
        .pos    (rd_pos),
        .din    (spi_miso),
        .data   (rdata)
    );

    // configuration registers, frozen while a frame runs
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            addr_q <= '0;
            wlo_q  <= '0;
            whi_q  <= '0;
            exec_q <= 1'b0;
        end else begin
            exec_q <= accept;
            if (cfg_wr) begin
                case (reg_sel_e'(reg_sel))
                    SEL_CTRL: cmd_q  <= unpack_cmd(reg_wdata);
                    SEL_ADDR: addr_q <= reg_wdata;
                    SEL_WLO:  wlo_q  <= reg_wdata;
                    SEL_WHI:  whi_q  <= reg_wdata;
                    default:  ;
                endcase
            end
        end
    end

    // frame sequencer: low half then high half per bit
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            cs_n_q <= 1'b1;
            bit_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            sclk_q <= 1'b0;
            cs_n_q <= 1'b0;
            bit_q  <= '0;
        end else if (busy_q && tick) begin
            if (!sclk_q) begin
                sclk_q <= 1'b1;
            end else begin
                sclk_q <= 1'b0;
                if (last_bit) begin
                    busy_q <= 1'b0;
                    cs_n_q <= 1'b1;
                end else begin
                    bit_q <= bit_q + BIT_W'(1);
                end
            end
        end
    end

    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_CTRL: reg_rdata = pack_cmd(cmd_q) | {30'b0, busy_q, exec_q};
            SEL_ADDR: reg_rdata = addr_q;
            SEL_WLO:  reg_rdata = wlo_q;
            SEL_WHI:  reg_rdata = whi_q;
            SEL_RLO:  reg_rdata = rdata[31:0];
            SEL_RHI:  reg_rdata = rdata[63:32];
            default:  reg_rdata = '0;
        endcase
    end

    assign spi_sclk = sclk_q;
    assign spi_cs_n = cs_n_q;
    assign spi_mosi = !cs_n_q && tx_bit;
endmodule

// File: rtl/fcmd_chk.sv
module fcmd_chk
    import fcmd_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic busy,
    input logic exec_pulse,
    input cmd_t cmd_word,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi
);
    timeunit 1ns;
    timeprecision 100ps;

    // R9
    cs_tracks_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy == !spi_cs_n);

    // R8
    idle_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    // R2
    exec_selfclear_chk: assert property (@(posedge clk) disable iff (rst)
        exec_pulse |=> !exec_pulse);

    // R3
    exec_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        exec_pulse |-> busy);

    // R10
    ctrl_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cmd_word));

    // R8
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> $stable(spi_mosi));

    // R9
    cs_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> !spi_sclk);
endmodule

bind fcmd_engine fcmd_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy_q),
    .exec_pulse (exec_q),
    .cmd_word   (cmd_q),
    .spi_cs_n   (spi_cs_n),
    .spi_sclk   (spi_sclk),
    .spi_mosi   (spi_mosi)
);

// File: tb/sim_fcmd_engine.sv
module sim_fcmd_engine;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int H = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  rd_sel = 3'd0;
    logic [31:0] reg_rdata;
    logic        sclk, cs_n, mosi;
    logic        miso = 1'b1;

    fcmd_engine #(.SCLK_HALF(H)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_sel(rd_sel), .reg_rdata(reg_rdata),
        .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    logic tx_bits [256];
    logic rx_bits [256];
    int   nbits = 0;
    logic [63:0] exp_rd = '0;
    bit   pending = 0, arm = 0, active = 0;
    int   t = 0;
    int unsigned seed = 32'h1234_5678;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    // build the expected bit stream from the requirement text
    task automatic build(input logic [31:0] ctrl, input logic [31:0] addr,
                         input logic [31:0] wlo, input logic [31:0] whi);
        int n = 0;
        int rd0;
        logic [63:0] wd = {whi, wlo};
        for (int b = 7; b >= 0; b--) begin tx_bits[n] = ctrl[24+b]; n++; end
        if (ctrl[19]) begin
            for (int i = int'(ctrl[17:16]); i >= 0; i--)
                for (int b = 7; b >= 0; b--) begin tx_bits[n] = addr[8*i+b]; n++; end
        end
        for (int d = 0; d < int'(ctrl[11:7]); d++) begin tx_bits[n] = 1'b0; n++; end
        if (ctrl[15]) begin
            for (int j = 0; j <= int'(ctrl[14:12]); j++)
                for (int b = 7; b >= 0; b--) begin tx_bits[n] = wd[8*j+b]; n++; end
        end
        rd0 = n;
        exp_rd = '0;
        for (int i = 0; i < 256; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            rx_bits[i] = seed[16];
        end
        if (ctrl[23]) begin
            for (int j = 0; j <= int'(ctrl[22:20]); j++)
                for (int b = 7; b >= 0; b--) begin
                    tx_bits[n] = 1'b0;
                    exp_rd[8*j+b] = rx_bits[n];
                    n++;
                end
        end
        if (rd0 < 0) nbits = 0;
        nbits = n;
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic e_sclk, e_mosi;
            if (active) begin
                t++;
                if (t == 2 * H * nbits) active = 0;
            end
            if (arm) begin active = 1; t = 0; arm = 0; end
            if (pending) begin arm = 1; pending = 0; end
            e_sclk = active && ((t % (2 * H)) >= H);
            e_mosi = active ? tx_bits[t / (2 * H)] : 1'b0;
            chk(cs_n == !active, "R9", "cs_n", 64'(cs_n), 64'(!active));
            chk(sclk == e_sclk, "R8", "sclk", 64'(sclk), 64'(e_sclk));
            chk(mosi == e_mosi, "R4", "mosi", 64'(mosi), 64'(e_mosi));
            if (rd_sel == 3'd0) begin
                chk(reg_rdata[1] == active, "R3", "busy", 64'(reg_rdata[1]), 64'(active));
                chk(reg_rdata[0] == (active && t == 0), "R2", "exec",
                    64'(reg_rdata[0]), 64'(active && t == 0));
            end
            miso = active ? rx_bits[t / (2 * H)] : 1'b1;
        end
    end

    task automatic wr(input logic [2:0] s, input logic [31:0] d, input bit go);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        if (go) pending = 1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] s, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        rd_sel = s;
        @(negedge clk);
        chk(reg_rdata == e, tag, "readback", 64'(reg_rdata), 64'(e));
        @(posedge clk); #1;
        rd_sel = 3'd0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (pending || arm || active);
    endtask

    task automatic run_cmd(input logic [31:0] ctrl, input logic [31:0] addr,
                           input logic [31:0] wlo, input logic [31:0] whi,
                           input bit intrude);
        wr(3'd1, addr, 0);
        wr(3'd2, wlo, 0);
        wr(3'd3, whi, 0);
        build(ctrl, addr, wlo, whi);
        wr(3'd0, ctrl | 32'h1, 1);
        if (intrude) begin
            repeat (30) @(posedge clk);
            // R10: all of these must be ignored
            wr(3'd0, 32'hFF80_0001, 0);
            wr(3'd1, 32'hDEAD_BEEF, 0);
            wr(3'd2, 32'h0, 0);
        end
        wait_idle();
        rd_check(3'd4, exp_rd[31:0], "R7");
        rd_check(3'd5, exp_rd[63:32], "R7");
        rd_check(3'd0, ctrl & 32'hFFFB_FF80, "R10");
        rd_check(3'd1, addr, "R10");
        rd_check(3'd2, wlo, "R10");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1", "pins",
            64'({cs_n, sclk, mosi}), 64'(3'b100));
        chk(reg_rdata == 32'h0, "R1", "ctrl", 64'(reg_rdata), 64'h0);
        rd_check(3'd4, 32'h0, "R1");
        rd_check(3'd1, 32'h0, "R1");

        // R7: read three bytes, opcode only
        run_cmd(32'h9FA0_0000, 32'h0, 32'h0, 32'h0, 0);
        // R5 R6: three address bytes (top byte not sent), eight send bytes
        run_cmd(32'h020A_F000, 32'h5AA1_B2C3, 32'h4433_2211, 32'h8877_6655, 0);
        // R5 R7 R10: four address bytes, eight dummy clocks, eight read bytes, writes while busy
        run_cmd(32'h0BFB_0400, 32'h1234_5678, 32'hCAFE_F00D, 32'h0BAD_1DEA, 1);
        // R4 R7: send two then read five, one address byte, three dummy clocks; upper read bytes cleared
        run_cmd(32'h5CC8_9180, 32'h0000_00E7, 32'h0000_A55A, 32'h0, 0);
        // R4: opcode alone
        run_cmd(32'h0600_0000, 32'h0, 32'h0, 32'h0, 0);

        // R11: field update without a frame
        wr(3'd0, 32'h33C4_0002, 0);
        repeat (12) @(posedge clk);
        rd_check(3'd0, 32'h33C0_0000, "R11");
        @(negedge clk);
        chk(cs_n == 1'b1, "R11", "no frame", 64'(cs_n), 64'h1);

        repeat (4) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5 * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired got %0d exp 0", 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule